// File: doc/BRIEF.md
# Bidirectional Iterative Shifter

This block shifts one data word left or right by a requested amount. It does not use a barrel shifter. It moves a working register by one bit position per clock, under a small state machine, so the logic per bit stays at a single two-way mux. The amount of work in each cycle therefore does not depend on the word width.

An operation comes in through a valid/ready pair carrying the data word, the shift amount and a direction bit. The block then runs one shift step per cycle. When the shift is finished it holds the result behind an output valid/ready pair until downstream takes it. Only one operation is in flight at a time, and the input side stays closed from acceptance until the result has been taken. Shifts are logical: vacated bits fill with zero and bits shifted out are lost.

Top module: `shf_iter_top`

## Requirements
- R1: With the direction bit at 1 the result is the data shifted right logically, zero filled from the top (13 shifted by 2 gives 3).
- R2: With the direction bit at 0 the result is the data shifted left logically, with bits pushed past the top bit discarded (3 shifted by 4 gives 48; 0xA5 shifted by 1 gives 0x4A).
- R3: A shift amount of 0 returns the data unchanged in either direction (21 gives 21).
- R4: Any shift amount from 8 up to 255 gives a result of 0 in either direction.
- R5: `in_ready` is high when idle. It is low from the cycle after an accepting edge (`in_valid` and `in_ready` both high) until the output handshake completes. `in_valid` and the input fields have no effect while `in_ready` is low.
- R6: `out_valid` first goes high at the clock edge that lies min(amount, 8) edges after the accepting edge. For an amount of 0 this is the accepting edge itself.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady. An edge with both high ends the operation, and `in_ready` is high and `out_valid` low after it.
- R8: `out_data` reads 0 whenever `out_valid` is low.
- R9: A synchronous active-high reset leaves `in_ready` at 1, `out_valid` at 0 and `out_data` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block idle and able to take an operation |
| in_data | input | 8 | Word to shift |
| in_amount | input | 8 | Number of bit positions to shift |
| in_dir | input | 1 | 1 = shift right, 0 = shift left |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 8 | Shifted word, 0 when no result is held |

## Verification
A step counter that is off by one shows up in two ways. `out_valid` rises one cycle early or late against the min(amount, 8) schedule, and the result is a factor of two off, so the fault is visible in the very operation where it occurs. A state machine stuck busy or leaving the hold state early appears at the ports within one cycle, as `in_ready` or `out_valid` disagreeing with the handshake history. The bench keeps a cycle-accurate model of both handshakes and of the result, and compares all three outputs on every clock. Requests made while the block is busy carry different data, so a leak of such a request shows up in the next result.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int unsigned SHF_DEF_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } shf_state_e;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shf_dir_e;

    function automatic logic goes_right(shf_dir_e d);
        return d == DIR_RIGHT;
    endfunction

endpackage

// File: rtl/shf_seq.sv
module shf_seq
    import shf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       zero_load,
    input  logic       last_step,
    input  logic       drain,
    output shf_state_e state
);
    shf_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)    state_nx = zero_load ? ST_HOLD : ST_RUN;
            ST_RUN:  if (last_step) state_nx = ST_HOLD;
            ST_HOLD: if (drain)     state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end
endmodule

// File: rtl/shf_step_cnt.sv
module shf_step_cnt #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AMT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [AMT_W-1:0] amount,
    output logic             zero_load,
    output logic             last_step
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Amounts at or above the width saturate: that many steps empty the word.
    always_comb begin
        if (amount >= AMT_W'(DATA_W)) load_val = CNT_W'(DATA_W);
        else                          load_val = CNT_W'(amount);
    end

    assign zero_load = (load_val == '0);
    assign last_step = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (step) cnt <= cnt - CNT_W'(1);
    end
endmodule

// File: rtl/shf_work_reg.sv
module shf_work_reg
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] load_data,
    input  shf_dir_e          load_dir,
    output logic [DATA_W-1:0] q
);
    shf_dir_e          dir_q;
    logic [DATA_W-1:0] toward_lsb;
    logic [DATA_W-1:0] toward_msb;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == DATA_W - 1) begin : g_top
            assign toward_lsb[i] = 1'b0;
        end else begin : g_mid_r
            assign toward_lsb[i] = q[i+1];
        end
        if (i == 0) begin : g_bot
            assign toward_msb[i] = 1'b0;
        end else begin : g_mid_l
            assign toward_msb[i] = q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            dir_q <= DIR_LEFT;
        end else if (load) begin
            q     <= load_data;
            dir_q <= load_dir;
        end else if (step) begin
            q     <= goes_right(dir_q) ? toward_lsb : toward_msb;
        end
    end
endmodule

// File: rtl/shf_iter_top.sv
module shf_iter_top
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W = SHF_DEF_W,
    parameter int unsigned AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [AMT_W-1:0]  in_amount,
    input  logic              in_dir,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    shf_state_e        state;
    logic              accept;
    logic              step;
    logic              drain;
    logic              zero_load;
    logic              last_step;
    logic [DATA_W-1:0] work_q;

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_HOLD);
    assign accept    = in_valid && in_ready;
    assign step      = (state == ST_RUN);
    assign drain     = out_valid && out_ready;
    assign out_data  = out_valid ? work_q : '0;

    shf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .zero_load (zero_load),
        .last_step (last_step),
        .drain     (drain),
        .state     (state)
    );

    shf_step_cnt #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (step),
        .amount    (in_amount),
        .zero_load (zero_load),
        .last_step (last_step)
    );

    shf_work_reg #(.DATA_W(DATA_W)) u_work (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (step),
        .load_data (in_data),
        .load_dir  (shf_dir_e'(in_dir)),
        .q         (work_q)
    );
endmodule

// File: rtl/shf_iter_chk.sv
module shf_iter_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AMT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [AMT_W-1:0]  in_amount,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    logic [15:0] wait_cnt;
    logic [15:0] exp_steps;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt  <= '0;
            exp_steps <= '0;
        end else if (in_valid && in_ready) begin
            wait_cnt  <= '0;
            exp_steps <= (in_amount >= AMT_W'(DATA_W)) ? 16'(DATA_W) : 16'(in_amount);
        end else if (!in_ready && !out_valid) begin
            wait_cnt  <= wait_cnt + 16'd1;
        end
    end

    // R5
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !in_ready);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R7
    release_idle_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> in_ready && !out_valid);

    // R3
    zero_amount_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_amount == '0) |=> out_valid);

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (wait_cnt == exp_steps));

    // R5
    exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));
endmodule

bind shf_iter_top shf_iter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_amount (in_amount),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/shf_iter_top_tb_top.sv
`timescale 1ns/1ps
module shf_iter_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic [7:0] in_amount = '0;
    logic       in_dir = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    shf_iter_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_amount (in_amount),
        .in_dir    (in_dir),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    function automatic int ref_shift(int d, int a, bit right);
        if (a >= 8) return 0;
        if (right) return d >> a;
        return (d << a) & 255;
    endfunction

    // Behavioural model: 0 idle, 1 shifting, 2 holding result.
    int m_phase = 0;
    int m_left  = 0;
    int m_res   = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_phase <= 0;
            m_left  <= 0;
            m_res   <= 0;
        end else if (m_phase == 0) begin
            if (in_valid) begin
                m_left  <= (in_amount >= 8) ? 8 : int'(in_amount);
                m_res   <= ref_shift(int'(in_data), int'(in_amount), in_dir);
                m_phase <= (in_amount == 0) ? 2 : 1;
            end
        end else if (m_phase == 1) begin
            m_left <= m_left - 1;
            if (m_left == 1) m_phase <= 2;
        end else if (out_ready) begin
            m_phase <= 0;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R5 in_ready", int'(in_ready), int'(m_phase == 0));
            check("R6 out_valid", int'(out_valid), int'(m_phase == 2));
            check("R8 out_data", int'(out_data), (m_phase == 2) ? m_res : 0);
        end
    end

    task automatic do_op(string tag, int d, int a, bit right, int hold, bit noise);
        int n;
        int exp_steps;
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = 8'(d);
        in_amount = 8'(a);
        in_dir    = right;
        @(negedge clk);
        if (noise) begin
            in_data   = 8'(d ^ 8'h5A);
            in_amount = 8'd1;
            in_dir    = ~right;
        end else begin
            in_valid = 1'b0;
        end
        exp_steps = (a >= 8) ? 8 : a;
        n = 0;
        while (!out_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        check({tag, " latency R6"}, n, exp_steps);
        check({tag, " result"}, int'(out_data), ref_shift(d, a, right));
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check({tag, " hold R7"}, int'(out_valid), 1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check({tag, " release R7"}, int'(in_ready), 1);
        check({tag, " release R7 valid"}, int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 in_ready", int'(in_ready), 1);
        check("R9 out_valid", int'(out_valid), 0);
        check("R9 out_data", int'(out_data), 0);
        rst = 1'b0;
        do_op("R1 13>>2", 13, 2, 1'b1, 0, 1'b0);
        do_op("R2 3<<4", 3, 4, 1'b0, 0, 1'b0);
        do_op("R3 21 by 0 right", 21, 0, 1'b1, 1, 1'b0);
        do_op("R3 21 by 0 left", 21, 0, 1'b0, 0, 1'b1);
        do_op("R4 FF<<8", 255, 8, 1'b0, 0, 1'b0);
        do_op("R4 80>>200", 128, 200, 1'b1, 2, 1'b0);
        do_op("R4 FF>>255", 255, 255, 1'b1, 0, 1'b1);
        do_op("R1 81>>7", 129, 7, 1'b1, 0, 1'b0);
        do_op("R2 A5<<1", 165, 1, 1'b0, 3, 1'b0);
        do_op("R5 busy ignore", 90, 3, 1'b0, 5, 1'b1);
        do_op("R7 backpressure", 200, 5, 1'b1, 6, 1'b1);
        do_op("R1 1>>1", 1, 1, 1'b1, 0, 1'b0);
        repeat (3) @(negedge clk);
        check("R5 idle after run", int'(in_ready), 1);
        // R9: reset in the middle of an operation
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'd77; in_amount = 8'd6; in_dir = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid-op in_ready", int'(in_ready), 1);
        check("R9 mid-op out_valid", int'(out_valid), 0);
        check("R9 mid-op out_data", int'(out_data), 0);
        rst = 1'b0;
        do_op("R2 after reset", 7, 2, 1'b0, 0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule